// File: doc/BRIEF.md
# Manchester Half-Bit Evaluator with Collision Reporting

This block sits behind the correlator of a contactless card receiver. For every bit period of a Manchester-coded card answer it receives two correlation magnitudes, one per half-bit, together with a strobe. From these two numbers it decides whether the bit is usable at all, which value it carries, or whether two cards answered at once and the bit is a collision. Decoded bits are packed into bytes for a downstream FIFO. Each byte carries a flag that says whether any of its bits collided.

Reception is tied to the transmitter. A pulse on `txDone` marks the end of a reader transmission. The evaluator then ignores a programmable number of bit periods, giving the card its guard time, before it arms. Once armed, the first valid bit opens a frame. The first invalid bit after that closes the frame and flushes any partial byte. The frame-relative index of the first collided bit is held for software-side readers until the next transmission ends.

Top module: `mbit_eval`

## Requirements
- R1: While `rstN` is low, all outputs are zero: `rxActive`, `byteValid`, `byteData`, `byteBits`, `byteColl`, `frameEnd`, `collSeen` and `collPos`.
- R2: A `txDone` pulse with `waitBits` = N > 0 makes the next N `bitStrobe` periods count as guard time. Those periods are ignored and `rxActive` stays 0. The Nth strobe raises `rxActive` one cycle later. With N = 0, `rxActive` is 1 in the cycle after `txDone`.
- R3: A bit is valid only when the larger magnitude is strictly greater than `minLevel`. Invalid bits that arrive while armed, before any valid bit, are ignored.
- R4: When no collision occurs, the bit value is 1 if `firstMag` > `secondMag` and 0 otherwise.
- R5: A valid bit is a collision when the smaller magnitude is strictly greater than floor(larger × `collLevel` / 16). A collided bit enters the byte as 0, and `byteColl` is set for the byte that contains it.
- R6: Bits are packed LSB first, so the first bit of the frame lands in `byteData[0]`. One cycle after the strobe of the 8th bit, `byteValid` pulses with `byteBits` = 8.
- R7: The first invalid bit after valid data ends the frame. One cycle later `frameEnd` pulses. If k bits are pending (1..7), `byteValid` pulses in the same cycle with `byteBits` = k and the pending bits right-aligned, upper bits zero. If no bits are pending, no byte is output.
- R8: On the first collision of a frame, `collSeen` rises and `collPos` takes that bit's index. The index counts valid bits from 0 at the start of the frame and saturates at its maximum. Both outputs then hold, through frame end, until the next `txDone` clears them to 0.
- R9: `txDone` takes priority over a `bitStrobe` in the same cycle. It discards pending bits without output and restarts the guard wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDone | input | 1 | Pulse marking the end of a reader transmission |
| waitBits | input | WAIT_W | Guard time in bit periods |
| minLevel | input | MAG_W | Validity threshold for the stronger half |
| collLevel | input | LVL_W | Collision level in sixteenths of the stronger half |
| bitStrobe | input | 1 | One pulse per bit period; magnitudes valid with it |
| firstMag | input | MAG_W | Correlation magnitude of the first half-bit |
| secondMag | input | MAG_W | Correlation magnitude of the second half-bit |
| rxActive | output | 1 | Guard time elapsed, evaluator armed or in a frame |
| byteValid | output | 1 | One-cycle strobe: byte toward the FIFO |
| byteData | output | BYTE_W | Packed bits, first bit in bit 0 |
| byteBits | output | CNT_W | Number of valid bits in `byteData` |
| byteColl | output | 1 | At least one bit of this byte collided |
| frameEnd | output | 1 | One-cycle strobe: frame closed by an invalid bit |
| collSeen | output | 1 | A collision occurred since the last `txDone` |
| collPos | output | POS_W | Frame index of the first collided bit |

## Verification
The bound checker watches several rules on every clock: the guard wait after `txDone` keeps the receiver off, `txDone` wipes outputs and collision state, and output strobes only follow a bit strobe. It also checks that a latched collision position never moves until the next transmission and that no byte carries an out-of-range bit count. The bench covers what needs arithmetic and history. This includes the exact packing order and partial-byte alignment, and the threshold boundaries where the weak half equals the scaled level or the strong half equals `minLevel`. It also covers collision levels 0 and 15, and a `txDone` that lands on a bit strobe halfway through a byte.

// File: rtl/mbe_pkg.sv
package mbe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ARMED = 2'd2,
    ST_DATA  = 2'd3
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrFrame;
    logic takeBit;
    logic flush;
  } dpCtl_t;

endpackage

// File: rtl/mbe_control.sv
module mbe_control
  import mbe_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txDone,
  input  logic [WAIT_W-1:0] waitBits,
  input  logic              bitStrobe,
  input  logic              bitOk,
  output dpCtl_t            ctl,
  output logic              rxActive
);

  rxState_t          state;
  logic [WAIT_W-1:0] waitCnt;

  assign rxActive = (state == ST_ARMED) || (state == ST_DATA);

  always_comb begin
    ctl = '0;
    if (txDone) begin
      ctl.clrFrame = 1'b1;
    end else if (bitStrobe) begin
      if (rxActive && bitOk)
        ctl.takeBit = 1'b1;
      else if (state == ST_DATA && !bitOk)
        ctl.flush = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else if (txDone) begin
      waitCnt <= waitBits;
      state   <= (waitBits == '0) ? ST_ARMED : ST_WAIT;
    end else if (bitStrobe) begin
      unique case (state)
        ST_WAIT: begin
          waitCnt <= waitCnt - WAIT_W'(1);
          if (waitCnt == WAIT_W'(1)) state <= ST_ARMED;
        end
        ST_ARMED: if (bitOk)  state <= ST_DATA;
        ST_DATA:  if (!bitOk) state <= ST_IDLE;
        default:  state <= state;
      endcase
    end
  end

endmodule

// File: rtl/mbe_datapath.sv
module mbe_datapath
  import mbe_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int LVL_W  = 4,
  parameter int POS_W  = 10,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MAG_W-1:0]  firstMag,
  input  logic [MAG_W-1:0]  secondMag,
  input  logic [MAG_W-1:0]  minLevel,
  input  logic [LVL_W-1:0]  collLevel,
  input  dpCtl_t            ctl,
  output logic              bitOk,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic [CNT_W-1:0]  byteBits,
  output logic              byteColl,
  output logic              frameEnd,
  output logic              collSeen,
  output logic [POS_W-1:0]  collPos
);

  localparam int PROD_W = MAG_W + LVL_W;

  logic              firstWins;
  logic [MAG_W-1:0]  strongMag, weakMag;
  logic [PROD_W-1:0] pp [LVL_W];
  logic [PROD_W-1:0] prod;
  logic              bitColl, bitVal;

  logic [BYTE_W-1:0] shReg, nextSh;
  logic [CNT_W-1:0]  bitCnt;
  logic              collAcc;
  logic [POS_W-1:0]  frameIdx;

  // magnitude ordering of the two halves
  assign firstWins = firstMag > secondMag;
  assign strongMag = firstWins ? firstMag : secondMag;
  assign weakMag   = firstWins ? secondMag : firstMag;

  // strong * level by shift-and-add
  for (genvar g = 0; g < LVL_W; g++) begin : g_pp
    assign pp[g] = collLevel[g] ? (PROD_W'(strongMag) << g) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < LVL_W; i++) prod = prod + pp[i];
  end

  // weak > floor(prod / 2^LVL_W)  <=>  weak * 2^LVL_W > prod
  assign bitOk   = strongMag > minLevel;
  assign bitColl = {weakMag, {LVL_W{1'b0}}} > prod;
  assign bitVal  = firstWins && !bitColl;
  assign nextSh  = {bitVal, shReg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      bitCnt    <= '0;
      collAcc   <= 1'b0;
      frameIdx  <= '0;
      collSeen  <= 1'b0;
      collPos   <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteBits  <= '0;
      byteColl  <= 1'b0;
      frameEnd  <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      frameEnd  <= 1'b0;
      if (ctl.clrFrame) begin
        shReg    <= '0;
        bitCnt   <= '0;
        collAcc  <= 1'b0;
        frameIdx <= '0;
        collSeen <= 1'b0;
        collPos  <= '0;
      end else if (ctl.takeBit) begin
        if (bitColl && !collSeen) begin
          collSeen <= 1'b1;
          collPos  <= frameIdx;
        end
        if (frameIdx != '1) frameIdx <= frameIdx + POS_W'(1);
        if (bitCnt == CNT_W'(BYTE_W - 1)) begin
          byteValid <= 1'b1;
          byteData  <= nextSh;
          byteBits  <= CNT_W'(BYTE_W);
          byteColl  <= collAcc | bitColl;
          shReg     <= '0;
          bitCnt    <= '0;
          collAcc   <= 1'b0;
        end else begin
          shReg   <= nextSh;
          bitCnt  <= bitCnt + CNT_W'(1);
          collAcc <= collAcc | bitColl;
        end
      end else if (ctl.flush) begin
        frameEnd  <= 1'b1;
        byteValid <= bitCnt != '0;
        byteData  <= shReg >> (CNT_W'(BYTE_W) - bitCnt);
        byteBits  <= bitCnt;
        byteColl  <= collAcc;
        shReg     <= '0;
        bitCnt    <= '0;
        collAcc   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mbit_eval.sv
module mbit_eval
  import mbe_pkg::*;
#(
  parameter int MAG_W  = 8,
  parameter int LVL_W  = 4,
  parameter int WAIT_W = 8,
  parameter int POS_W  = 10,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txDone,
  input  logic [WAIT_W-1:0] waitBits,
  input  logic [MAG_W-1:0]  minLevel,
  input  logic [LVL_W-1:0]  collLevel,
  input  logic              bitStrobe,
  input  logic [MAG_W-1:0]  firstMag,
  input  logic [MAG_W-1:0]  secondMag,
  output logic              rxActive,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic [CNT_W-1:0]  byteBits,
  output logic              byteColl,
  output logic              frameEnd,
  output logic              collSeen,
  output logic [POS_W-1:0]  collPos
);

  dpCtl_t ctl;
  logic   bitOk;

  mbe_control #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txDone(txDone), .waitBits(waitBits),
    .bitStrobe(bitStrobe), .bitOk(bitOk), .ctl(ctl), .rxActive(rxActive)
  );

  mbe_datapath #(
    .MAG_W(MAG_W), .LVL_W(LVL_W), .POS_W(POS_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .firstMag(firstMag), .secondMag(secondMag),
    .minLevel(minLevel), .collLevel(collLevel), .ctl(ctl), .bitOk(bitOk),
    .byteValid(byteValid), .byteData(byteData), .byteBits(byteBits),
    .byteColl(byteColl), .frameEnd(frameEnd), .collSeen(collSeen),
    .collPos(collPos)
  );

endmodule

// File: rtl/mbit_eval_chk.sv
module mbit_eval_chk #(
  parameter int WAIT_W = 8,
  parameter int POS_W  = 10,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              txDone,
  input logic [WAIT_W-1:0] waitBits,
  input logic              bitStrobe,
  input logic              rxActive,
  input logic              byteValid,
  input logic [CNT_W-1:0]  byteBits,
  input logic              frameEnd,
  input logic              collSeen,
  input logic [POS_W-1:0]  collPos
);

  a_r2_guard_off: assert property (@(posedge clk) disable iff (!rstN)
    txDone && waitBits != '0 |=> !rxActive);

  a_r2_zero_wait_on: assert property (@(posedge clk) disable iff (!rstN)
    txDone && waitBits == '0 |=> rxActive);

  a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    byteValid || frameEnd |-> $past(bitStrobe) && !$past(txDone));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> byteBits != '0 && byteBits <= CNT_W'(BYTE_W));

  a_r7_frame_closed: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> !rxActive);

  a_r8_pos_hold: assert property (@(posedge clk) disable iff (!rstN)
    collSeen && !txDone |=> collSeen && $stable(collPos));

  a_r9_tx_wipes: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !byteValid && !frameEnd && !collSeen && collPos == '0);

endmodule

bind mbit_eval mbit_eval_chk #(
  .WAIT_W(WAIT_W), .POS_W(POS_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .txDone(txDone), .waitBits(waitBits),
  .bitStrobe(bitStrobe), .rxActive(rxActive), .byteValid(byteValid),
  .byteBits(byteBits), .frameEnd(frameEnd), .collSeen(collSeen),
  .collPos(collPos)
);

// File: tb/mbit_eval_test.sv
`timescale 1ns/1ps
module mbit_eval_test;

  logic       clk = 1'b0;
  logic       rstN, txDone, bitStrobe;
  logic [7:0] waitBits, minLevel, firstMag, secondMag;
  logic [3:0] collLevel;
  logic       rxActive, byteValid, byteColl, frameEnd, collSeen;
  logic [7:0] byteData;
  logic [3:0] byteBits;
  logic [9:0] collPos;

  always #4 clk = ~clk;

  mbit_eval uut (
    .clk(clk), .rstN(rstN), .txDone(txDone), .waitBits(waitBits),
    .minLevel(minLevel), .collLevel(collLevel), .bitStrobe(bitStrobe),
    .firstMag(firstMag), .secondMag(secondMag), .rxActive(rxActive),
    .byteValid(byteValid), .byteData(byteData), .byteBits(byteBits),
    .byteColl(byteColl), .frameEnd(frameEnd), .collSeen(collSeen),
    .collPos(collPos)
  );

  int checks = 0, errors = 0;
  // reference model state: 0 idle, 1 guard, 2 armed, 3 in frame
  int mState, mWait, mAcc, mBits, mCacc, mIdx, mSeen, mPos;
  int eBV, eBD, eBB, eBC, eFE;
  int lastData, lastBits, lastColl, byteCount, endCount;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mState = 0; mWait = 0; mAcc = 0; mBits = 0; mCacc = 0;
    mIdx = 0; mSeen = 0; mPos = 0;
    eBV = 0; eBD = 0; eBB = 0; eBC = 0; eFE = 0;
  endtask

  task automatic modelStep();
    int s, w, thr;
    bit ok, col, val;
    eBV = 0; eFE = 0;
    if (txDone) begin
      mAcc = 0; mBits = 0; mCacc = 0; mIdx = 0; mSeen = 0; mPos = 0;
      mWait = int'(waitBits);
      mState = (mWait == 0) ? 2 : 1;
    end else if (bitStrobe) begin
      s = (firstMag > secondMag) ? int'(firstMag) : int'(secondMag);
      w = (firstMag > secondMag) ? int'(secondMag) : int'(firstMag);
      thr = (s * int'(collLevel)) / 16;
      ok = s > int'(minLevel);
      col = w > thr;
      val = (firstMag > secondMag) && !col;
      if (mState == 1) begin
        mWait--;
        if (mWait == 0) mState = 2;
      end else if (mState >= 2 && ok) begin
        mState = 3;
        if (val) mAcc = mAcc | (1 << mBits);
        mBits++;
        if (col) begin
          mCacc = 1;
          if (mSeen == 0) begin mSeen = 1; mPos = mIdx; end
        end
        if (mIdx < 1023) mIdx++;
        if (mBits == 8) begin
          eBV = 1; eBD = mAcc; eBB = 8; eBC = mCacc;
          mAcc = 0; mBits = 0; mCacc = 0;
        end
      end else if (mState == 3) begin
        eFE = 1;
        if (mBits > 0) begin eBV = 1; eBD = mAcc; eBB = mBits; eBC = mCacc; end
        mAcc = 0; mBits = 0; mCacc = 0; mState = 0;
      end
    end
  endtask

  task automatic compareAll();
    check(rxActive == (mState >= 2), "R2", "rxActive", int'(rxActive), int'(mState >= 2));
    check(byteValid == eBV[0], "R6", "byteValid", int'(byteValid), eBV);
    check(frameEnd == eFE[0], "R7", "frameEnd", int'(frameEnd), eFE);
    check(collSeen == mSeen[0], "R8", "collSeen", int'(collSeen), mSeen);
    check(int'(collPos) == mPos, "R8", "collPos", int'(collPos), mPos);
    if (byteValid && eBV == 1) begin
      check(int'(byteData) == eBD, "R4", "byteData", int'(byteData), eBD);
      check(int'(byteBits) == eBB, "R7", "byteBits", int'(byteBits), eBB);
      check(int'(byteColl) == eBC, "R5", "byteColl", int'(byteColl), eBC);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    modelStep();
    compareAll();
    if (byteValid) begin
      lastData = int'(byteData); lastBits = int'(byteBits);
      lastColl = int'(byteColl); byteCount++;
    end
    if (frameEnd) endCount++;
  endtask

  task automatic sendBit(input int f, input int s, input int gap);
    bitStrobe = 1'b1; firstMag = 8'(f); secondMag = 8'(s);
    cyc();
    bitStrobe = 1'b0;
    repeat (gap) cyc();
  endtask

  task automatic sendByte(input int b, input int gap);
    for (int i = 0; i < 8; i++)
      if (b[i]) sendBit(100, 10, gap); else sendBit(10, 100, gap);
  endtask

  task automatic pulseTx(input int wb);
    waitBits = 8'(wb); txDone = 1'b1;
    cyc();
    txDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bc, ec;
    rstN = 1'b0; txDone = 1'b0; bitStrobe = 1'b0; waitBits = '0;
    minLevel = 8'd20; collLevel = 4'd8; firstMag = '0; secondMag = '0;
    byteCount = 0; endCount = 0; lastData = 0; lastBits = 0; lastColl = 0;
    modelReset();
    bitStrobe = 1'b1; firstMag = 8'd200; txDone = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!rxActive && !byteValid && !frameEnd && !collSeen && !byteColl,
          "R1", "reset flags", int'(rxActive | byteValid | frameEnd | collSeen), 0);
    check(byteData == '0 && byteBits == '0 && collPos == '0,
          "R1", "reset data", int'(byteData), 0);
    bitStrobe = 1'b0; txDone = 1'b0; firstMag = '0;
    rstN = 1'b1;
    cyc();

    // R2/R6/R4: guard of 3 bits then a clean byte
    pulseTx(3);
    check(!rxActive, "R2", "off after txDone", int'(rxActive), 0);
    bc = byteCount;
    sendBit(100, 10, 1); sendBit(10, 100, 0); sendBit(100, 10, 2);
    check(rxActive, "R2", "armed after guard", int'(rxActive), 1);
    sendByte(8'hA5, 0);
    check(byteCount == bc + 1 && lastData == 8'hA5, "R6", "lsb-first byte", lastData, 8'hA5);
    check(lastBits == 8 && lastColl == 0, "R6", "full count", lastBits, 8);
    bc = byteCount; ec = endCount;
    sendBit(5, 5, 1);
    check(endCount == ec + 1 && byteCount == bc, "R7", "end without partial", byteCount - bc, 0);
    check(!rxActive, "R7", "off after end", int'(rxActive), 0);

    // R3/R7: zero guard, invalid bits before data, partial byte
    pulseTx(0);
    check(rxActive, "R2", "zero guard", int'(rxActive), 1);
    ec = endCount;
    sendBit(5, 5, 0); sendBit(20, 0, 1); sendBit(0, 20, 0);
    check(endCount == ec && rxActive, "R3", "pre-frame invalid ignored", endCount - ec, 0);
    sendBit(100, 10, 0); sendBit(10, 100, 0); sendBit(100, 10, 1);
    sendBit(100, 10, 0); sendBit(10, 100, 0);
    sendBit(3, 4, 1);
    check(lastData == 8'h0D && lastBits == 5, "R7", "partial data", lastData, 8'h0D);

    // R5/R8: collisions, weak at threshold
    pulseTx(1);
    sendBit(10, 200, 0);
    sendBit(100, 10, 0); sendBit(10, 100, 0); sendBit(100, 10, 0);
    sendBit(100, 60, 0); sendBit(100, 10, 0); sendBit(60, 100, 0);
    sendBit(100, 10, 0); sendBit(100, 10, 0);
    check(lastData == 8'hD5 && lastColl == 1, "R5", "collided byte", lastData, 8'hD5);
    check(collSeen && collPos == 10'd3, "R8", "first coll index", int'(collPos), 3);
    sendBit(96, 48, 0);
    sendBit(1, 1, 0);
    check(lastData == 1 && lastBits == 1 && lastColl == 0, "R5", "weak equals level", lastColl, 0);
    check(collSeen && collPos == 10'd3, "R8", "held past frame end", int'(collPos), 3);
    pulseTx(0);
    check(!collSeen && collPos == '0, "R8", "cleared by txDone", int'(collSeen), 0);

    // R5: extreme collision levels
    collLevel = 4'd0;
    sendBit(100, 1, 0);
    collLevel = 4'd15;
    sendBit(160, 150, 0); sendBit(160, 151, 0);
    sendBit(0, 0, 0);
    check(lastData == 2 && lastBits == 3 && lastColl == 1, "R5", "level 0 and 15", lastData, 2);
    check(collPos == 10'd0, "R8", "index zero", int'(collPos), 0);

    // R9: txDone with a strobe mid-byte
    collLevel = 4'd8;
    pulseTx(0);
    sendBit(100, 10, 0); sendBit(100, 10, 0); sendBit(10, 100, 0); sendBit(100, 10, 0);
    bc = byteCount; ec = endCount;
    waitBits = 8'd0; txDone = 1'b1; bitStrobe = 1'b1; firstMag = 8'd3; secondMag = 8'd3;
    cyc();
    txDone = 1'b0; bitStrobe = 1'b0;
    cyc();
    check(byteCount == bc && endCount == ec, "R9", "pending bits dropped", byteCount - bc, 0);
    sendByte(8'h3C, 1);
    check(lastData == 8'h3C && lastBits == 8, "R9", "fresh byte after restart", lastData, 8'h3C);
    // restart during guard
    pulseTx(4);
    sendBit(100, 10, 0); sendBit(100, 10, 0);
    pulseTx(2);
    sendBit(100, 10, 0);
    check(!rxActive, "R2", "guard restarted", int'(rxActive), 0);
    sendBit(100, 10, 0);
    check(rxActive, "R2", "guard done", int'(rxActive), 1);
    repeat (3) cyc();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule